// File: doc/BRIEF.md
# Double-Buffered Framebuffer Address Flip

This block keeps two framebuffer base addresses for a single display pipe and tells the scan-out engine which one to read. Each base address is stored as a low word and a high word in separate registers. The active address appears on `scan_base` as `{high word, low word}` of the selected buffer.

Software asks for a buffer swap by writing the trigger bit of the control register. The swap does not happen at the write. It is held and applied on the next vertical-blank strobe. On that strobe the active selection toggles and a one-cycle `flip_done` pulse is emitted. A read-only flag in the control register shows which buffer is currently in use. Triggering again after a swap has completed returns the pipe to the other buffer. A trigger written while a swap is still waiting does not queue a second swap.

Top module: `fbf_flip_top`

## Requirements
- R1: After a synchronous active-low reset, buffer 0 is active, no swap is pending, all four address words read 0, `scan_base` is 0 and `flip_done` is 0.
- R2: Register indices 1, 2, 3 and 4 hold buffer 0 low word, buffer 0 high word, buffer 1 low word and buffer 1 high word. A write is readable on `reg_rd_data` from the cycle after it is accepted.
- R3: `scan_base` equals `{high, low}` of the active buffer, so `scan_base[31:0]` is the low word. A write to a word of the active buffer shows on `scan_base` in the cycle after the write. A write to the inactive buffer leaves `scan_base` unchanged.
- R4: A write to index 0 with bit 7 set arms a swap. `active_buf` does not change until a vblank strobe is sampled in a later cycle.
- R5: On the first vblank strobe after a swap is armed, `active_buf` toggles at that clock edge. `flip_done` is high for exactly the one following cycle.
- R6: A second trigger written while a swap is still pending does not queue another swap. Only one toggle happens, and a later vblank changes nothing.
- R7: Triggering again after a completed swap swaps back to the previously used buffer.
- R8: Reading index 0 returns the active buffer number in bit 11 and 0 in all other bits. Writes to bit 11, or to any control bit other than bit 7, have no effect.
- R9: A vblank strobe with no swap pending leaves `active_buf` unchanged and produces no `flip_done`.
- R10: A trigger accepted in the same cycle as a vblank strobe counts only for later strobes. If nothing was pending, no swap happens on that strobe. If a swap was pending, that swap is applied and the new trigger arms another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data, combinational from `reg_rd_idx` |
| vblank | input | 1 | One-cycle vertical-blank strobe |
| scan_base | output | 64 | Base address of the active buffer |
| active_buf | output | 1 | Number of the buffer in use |
| flip_done | output | 1 | One-cycle pulse after a swap is applied |

## Verification
A trigger write and a vblank strobe can be sampled at the same clock edge, and the outcome depends on whether a swap was already pending. The bench drives both inputs together from the same falling edge in two cases. In the first case nothing is pending, so it expects no swap and no pulse, and then a swap on the following strobe. In the second case a swap is already pending, so it expects the pending swap to apply with a pulse, and then a further swap on the next strobe, which shows that the coincident trigger was retained.

// File: rtl/fbf_pkg.sv
// Package: shared constants for the framebuffer flip block.
// Assumes a 32-bit register port and a small word-indexed register space.
package fbf_pkg;
    parameter int DATA_W   = 32;
    parameter int IDX_W    = 3;
    parameter int NUM_BUF  = 2;
    localparam int BASE_W  = 2 * DATA_W;

    // Control register and its bit positions
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam int TRIG_BIT = 7;
    localparam int ACT_BIT  = 11;

    // Address words: buffer b low word at 1+2b, high word at 2+2b
    function automatic logic [IDX_W-1:0] lo_idx(input int b);
        return IDX_W'(1 + 2 * b);
    endfunction

    function automatic logic [IDX_W-1:0] hi_idx(input int b);
        return IDX_W'(2 + 2 * b);
    endfunction
endpackage

// File: rtl/fbf_addr_regs.sv
// Module: fbf_addr_regs
// Holds the low and high address words of every buffer.
// Assumes at most one write per cycle; unknown indices are ignored here.
module fbf_addr_regs
    import fbf_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_BUF-1:0][DATA_W-1:0]     lo_o,
    output logic [NUM_BUF-1:0][DATA_W-1:0]     hi_o
);
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        localparam logic [IDX_W-1:0] LO_I = lo_idx(b);
        localparam logic [IDX_W-1:0] HI_I = hi_idx(b);

        // Low word storage for buffer b
        always_ff @(posedge clk) begin
            if (!rst_n)                          lo_o[b] <= '0;
            else if (wr_en && wr_idx == LO_I)    lo_o[b] <= wr_data;
        end

        // High word storage for buffer b
        always_ff @(posedge clk) begin
            if (!rst_n)                          hi_o[b] <= '0;
            else if (wr_en && wr_idx == HI_I)    hi_o[b] <= wr_data;
        end

        p_lo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == LO_I) |=> (lo_o[b] == $past(wr_data)));
        p_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == HI_I) |=> (hi_o[b] == $past(wr_data)));
    end
endmodule

// File: rtl/fbf_flip_seq.sv
// Module: fbf_flip_seq
// Latches flip triggers and applies them at the next vblank strobe.
// A trigger only counts for strobes in later cycles. A pending request
// absorbs further triggers until it is consumed.
module fbf_flip_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic vblank,
    output logic active_o,
    output logic done_o
);
    logic pend_q;
    logic apply;

    assign apply = vblank && pend_q;

    // Pending request: consumed by vblank, re-armed by any trigger
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !vblank) || trig;
    end

    // Active selection toggles when a pending request is applied
    always_ff @(posedge clk) begin
        if (!rst_n)     active_o <= 1'b0;
        else if (apply) active_o <= ~active_o;
    end

    // One-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= apply;
    end

    p_trig_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pend_q);
    p_hold_no_vblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> $stable(active_o));
    p_swap_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && pend_q) |=> (done_o && active_o != $past(active_o)));
    p_idle_vblank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !pend_q) |=> (!done_o && $stable(active_o)));
endmodule

// File: rtl/fbf_read_mux.sv
// Module: fbf_read_mux
// Combinational read-back of control status and address words.
// Assumes unmapped indices read as zero.
module fbf_read_mux
    import fbf_pkg::*;
(
    input  logic [IDX_W-1:0]                   rd_idx,
    input  logic                               active,
    input  logic [NUM_BUF-1:0][DATA_W-1:0]     lo_i,
    input  logic [NUM_BUF-1:0][DATA_W-1:0]     hi_i,
    output logic [DATA_W-1:0]                  rd_data
);
    // Select the word addressed by rd_idx
    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_CTRL) rd_data[ACT_BIT] = active;
        for (int b = 0; b < NUM_BUF; b++) begin
            if (rd_idx == lo_idx(b)) rd_data = lo_i[b];
            if (rd_idx == hi_idx(b)) rd_data = hi_i[b];
        end
    end
endmodule

// File: rtl/fbf_flip_top.sv
// Module: fbf_flip_top
// Double-buffered framebuffer base selection for one display pipe.
// Assumes vblank is a one-cycle strobe in the clk domain.
module fbf_flip_top
    import fbf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [IDX_W-1:0]     reg_wr_idx,
    input  logic [DATA_W-1:0]    reg_wr_data,
    input  logic [IDX_W-1:0]     reg_rd_idx,
    output logic [DATA_W-1:0]    reg_rd_data,
    input  logic                 vblank,
    output logic [BASE_W-1:0]    scan_base,
    output logic                 active_buf,
    output logic                 flip_done
);
    logic [NUM_BUF-1:0][DATA_W-1:0] lo_w;
    logic [NUM_BUF-1:0][DATA_W-1:0] hi_w;
    logic trig;

    // Trigger decode: control write with the trigger bit set
    assign trig = reg_wr_en && (reg_wr_idx == IDX_CTRL) && reg_wr_data[TRIG_BIT];

    fbf_addr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_idx(reg_wr_idx),
        .wr_data(reg_wr_data), .lo_o(lo_w), .hi_o(hi_w)
    );

    fbf_flip_seq u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .vblank(vblank),
        .active_o(active_buf), .done_o(flip_done)
    );

    fbf_read_mux u_rd (
        .rd_idx(reg_rd_idx), .active(active_buf), .lo_i(lo_w), .hi_i(hi_w),
        .rd_data(reg_rd_data)
    );

    // Base address of the selected buffer
    always_comb scan_base = {hi_w[active_buf], lo_w[active_buf]};

    p_base_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scan_base) |-> ($past(reg_wr_en) || flip_done));
endmodule

// File: tb/fbf_flip_top_bench.sv
module fbf_flip_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_idx = '0;
    logic [31:0] reg_rd_data;
    logic        vblank = 1'b0;
    logic [63:0] scan_base;
    logic        active_buf;
    logic        flip_done;

    int n_chk = 0;
    int n_bad = 0;
    logic got_done;

    always #10 clk = ~clk;

    fbf_flip_top u_fbf_flip_top (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .vblank(vblank), .scan_base(scan_base), .active_buf(active_buf),
        .flip_done(flip_done)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_rd_idx = idx;
        #1 d = reg_rd_data;
    endtask

    // Strobe vblank, optionally with a trigger in the same cycle; capture flip_done
    task automatic vb(input logic with_trig);
        @(negedge clk);
        vblank = 1'b1;
        if (with_trig) begin
            reg_wr_en = 1'b1; reg_wr_idx = 3'd0; reg_wr_data = 32'h80;
        end
        @(negedge clk);
        got_done = flip_done;
        vblank = 1'b0; reg_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 active", active_buf, 0);
        check("R1 done", flip_done, 0);
        check("R1 base", scan_base, 0);
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), d);
            check("R1 readback", d, 0);
        end
    endtask

    task automatic t_addr;
        logic [31:0] d;
        wr(3'd1, 32'h1111_0000); wr(3'd2, 32'h0000_00A5);
        wr(3'd3, 32'h2222_0004); wr(3'd4, 32'h0000_00B6);
        rd(3'd1, d); check("R2 b0 lo", d, 32'h1111_0000);
        rd(3'd2, d); check("R2 b0 hi", d, 32'h0000_00A5);
        rd(3'd3, d); check("R2 b1 lo", d, 32'h2222_0004);
        rd(3'd4, d); check("R2 b1 hi", d, 32'h0000_00B6);
        check("R3 base b0", scan_base, 64'h0000_00A5_1111_0000);
    endtask

    task automatic t_flip_basic;
        logic [31:0] d;
        wr(3'd0, 32'h80);
        repeat (3) @(negedge clk);
        check("R4 held", active_buf, 0);
        rd(3'd0, d); check("R8 status before", d, 32'h0);
        vb(1'b0);
        check("R5 done", got_done, 1);
        check("R5 active", active_buf, 1);
        check("R3 base b1", scan_base, 64'h0000_00B6_2222_0004);
        rd(3'd0, d); check("R8 status after", d, 32'h800);
        @(negedge clk);
        check("R5 pulse one cycle", flip_done, 0);
    endtask

    task automatic t_idle_vblank;
        vb(1'b0);
        check("R9 no done", got_done, 0);
        check("R9 active", active_buf, 1);
    endtask

    task automatic t_double_trig;
        wr(3'd0, 32'h80); wr(3'd0, 32'h80);
        vb(1'b0);
        check("R6 done", got_done, 1);
        check("R6 one swap", active_buf, 0);
        vb(1'b0);
        check("R6 no queued done", got_done, 0);
        check("R6 no queued swap", active_buf, 0);
    endtask

    task automatic t_swap_back;
        wr(3'd0, 32'h80); vb(1'b0);
        check("R7 to 1", active_buf, 1);
        wr(3'd0, 32'h80); vb(1'b0);
        check("R7 back to 0", active_buf, 0);
        check("R7 base", scan_base, 64'h0000_00A5_1111_0000);
    endtask

    task automatic t_ctrl_ro;
        logic [31:0] d;
        wr(3'd0, 32'hFFFF_FF7F);
        check("R8 ro bit", active_buf, 0);
        rd(3'd0, d); check("R8 readback", d, 32'h0);
        vb(1'b0);
        check("R8 no arm done", got_done, 0);
        check("R8 no arm active", active_buf, 0);
    endtask

    task automatic t_same_cycle;
        vb(1'b1);
        check("R10 idle+trig no done", got_done, 0);
        check("R10 idle+trig active", active_buf, 0);
        vb(1'b0);
        check("R10 later done", got_done, 1);
        check("R10 later active", active_buf, 1);
        wr(3'd0, 32'h80);
        vb(1'b1);
        check("R10 pend+trig done", got_done, 1);
        check("R10 pend+trig active", active_buf, 0);
        vb(1'b0);
        check("R10 rearmed done", got_done, 1);
        check("R10 rearmed active", active_buf, 1);
    endtask

    task automatic t_live_update;
        wr(3'd3, 32'hCAFE_0000);
        check("R3 active lo live", scan_base, 64'h0000_00B6_CAFE_0000);
        wr(3'd2, 32'h0000_0FFF);
        check("R3 inactive ignored", scan_base, 64'h0000_00B6_CAFE_0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_flip_basic();
        t_idle_vblank();
        t_double_trig();
        t_swap_back();
        t_ctrl_ro();
        t_same_cycle();
        t_live_update();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule